// File: doc/BRIEF.md
# Bus Protocol Interval Timers

This block keeps the timing rules that a device on a parallel, handshaked peripheral bus must follow around arbitration, selection, disconnection and bus reset. A device state machine sends it one-cycle start and clear strobes. The block answers with a busy and a done flag for each interval. It also produces a stretched bus reset output, a window during which a busy response is still allowed after selection, and a power-on ready flag. It makes no arbitration decision and drives no bus line other than the reset request it stretches.

Every interval is given in nanoseconds. It is turned into a clock cycle count at elaboration, using a clock-rate parameter in kHz. Intervals that are a floor on waiting time are rounded up, so they are never cut short. Intervals that are a ceiling are rounded down, so they are never overrun. A count is never less than one cycle. The defaults are:

- 2.4 µs: arbitration settle, before the data bus is examined.
- 250 ms: selection timeout, while waiting for a busy response.
- 200 µs: selection-response window, after the latest detection of selection.
- 200 µs: disconnect holdoff, before the device joins a new arbitration.
- 25 µs: bus reset hold.
- 10 s: power-on ready limit.

The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `bus_phase_timers`

## Requirements
- R1: The five timers sit at these bit positions of `tmr_start`, `tmr_clr`, `tmr_busy` and `tmr_done`: arbitration settle 0, selection timeout 1, response window 2, disconnect holdoff 3, bus reset 4. A start strobe sampled at a clock edge sets busy after that edge. Done rises exactly N edges after the start edge, and busy falls at that same edge. Done then stays high until a clear or a new start.
- R2: For the arbitration settle, selection timeout, disconnect holdoff and bus reset timers, N = ceil(ns × CLK_KHZ / 1e6).
- R3: For the response window and power-on ready, N = floor(ns × CLK_KHZ / 1e6). Any count that works out below one is raised to one.
- R4: A start strobe that arrives while a timer is busy restarts that timer from zero. Its done then rises N edges after the latest start edge.
- R5: A clear strobe drops busy and done at the edge where it is sampled, and no done follows. If clear and start are sampled at the same edge, clear wins.
- R6: `bsy_window_o` is high for exactly N_window cycles after a selection-detect strobe, and low once that window ends. The end of the window is reported by done bit 2.
- R7: `bus_rst_o` is high for exactly N_rst cycles after a reset request. A request made during the hold extends it to N_rst cycles after the latest request.
- R8: `por_ready_o` rises N_por edges after `rst_n` is released and then stays high.
- R9: While `rst_n` is low, all busy, done, window, reset and ready outputs are 0.
- R10: For each timer, busy and done are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_start | input | 5 | One-cycle start or restart strobe, one bit per timer |
| tmr_clr | input | 5 | One-cycle cancel strobe, one bit per timer |
| tmr_busy | output | 5 | Timer is counting |
| tmr_done | output | 5 | Interval has elapsed; held until clear or restart |
| bsy_window_o | output | 1 | Busy response to a selection is still allowed |
| bus_rst_o | output | 1 | Stretched bus reset drive |
| por_ready_o | output | 1 | Power-on ready |

## Verification
Done is due N edges after the edge that samples start. Busy is due one edge after start. The window and reset outputs stay high for exactly N cycles. Power-on ready is due N_por edges after reset is released.

The driver task records the cycle number of the start edge and pushes the cycle at which done is due into a queue for that timer. It empties that queue on a restart or a clear. A monitor samples on falling clock edges. It matches each rising done against the head of the queue by cycle number, and it counts the high cycles of the window and reset outputs.

The bench uses a small clock-rate parameter with odd nanosecond values. This makes the ceiling and floor roundings produce different counts.

// File: rtl/bus_tmr_pkg.sv
package bus_tmr_pkg;

  localparam int NTMR     = 5;
  localparam int TM_ARB   = 0;
  localparam int TM_SELTO = 1;
  localparam int TM_GUARD = 2;
  localparam int TM_DISC  = 3;
  localparam int TM_RST   = 4;

  // minimum-type interval: never shorter than asked
  function automatic longint unsigned cyc_ceil(longint unsigned ns, longint unsigned khz);
    longint unsigned r;
    r = (ns * khz + 64'd999_999) / 64'd1_000_000;
    return (r == 0) ? 64'd1 : r;
  endfunction

  // maximum-type interval: never longer than allowed
  function automatic longint unsigned cyc_floor(longint unsigned ns, longint unsigned khz);
    longint unsigned r;
    r = (ns * khz) / 64'd1_000_000;
    return (r == 0) ? 64'd1 : r;
  endfunction

  function automatic int unsigned cnt_width(longint unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter longint unsigned COUNT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic busy,
  output logic done
);
  localparam int unsigned W = bus_tmr_pkg::cnt_width(COUNT);
  localparam logic [W-1:0] LOAD = W'(COUNT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (clr) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= LOAD;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/por_gate.sv
module por_gate #(
  parameter longint unsigned COUNT = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int unsigned W = bus_tmr_pkg::cnt_width(COUNT);
  localparam logic [W-1:0] LAST = W'(COUNT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_phase_timers.sv
module bus_phase_timers #(
  parameter longint unsigned CLK_KHZ  = 250_000,
  parameter longint unsigned ARB_NS   = 2_400,
  parameter longint unsigned SELTO_NS = 250_000_000,
  parameter longint unsigned GUARD_NS = 200_000,
  parameter longint unsigned DISC_NS  = 200_000,
  parameter longint unsigned RST_NS   = 25_000,
  parameter longint unsigned POR_NS   = 64'd10_000_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] tmr_start,
  input  logic [4:0] tmr_clr,
  output logic [4:0] tmr_busy,
  output logic [4:0] tmr_done,
  output logic       bsy_window_o,
  output logic       bus_rst_o,
  output logic       por_ready_o
);
  import bus_tmr_pkg::*;

  localparam longint unsigned N_POR = cyc_floor(POR_NS, CLK_KHZ);

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam longint unsigned N =
      (g == TM_ARB)   ? cyc_ceil (ARB_NS,   CLK_KHZ) :
      (g == TM_SELTO) ? cyc_ceil (SELTO_NS, CLK_KHZ) :
      (g == TM_GUARD) ? cyc_floor(GUARD_NS, CLK_KHZ) :
      (g == TM_DISC)  ? cyc_ceil (DISC_NS,  CLK_KHZ) :
                        cyc_ceil (RST_NS,   CLK_KHZ);
    ivl_timer #(.COUNT(N)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start[g]),
      .clr   (tmr_clr[g]),
      .busy  (tmr_busy[g]),
      .done  (tmr_done[g])
    );
  end

  assign bsy_window_o = tmr_busy[TM_GUARD];
  assign bus_rst_o    = tmr_busy[TM_RST];

  por_gate #(.COUNT(N_POR)) u_por (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (por_ready_o)
  );
endmodule

// File: rtl/bus_phase_timers_chk.sv
module bus_phase_timers_chk #(
  parameter longint unsigned RST_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] tmr_start,
  input logic [4:0] tmr_clr,
  input logic [4:0] tmr_busy,
  input logic [4:0] tmr_done,
  input logic       bsy_window_o,
  input logic       bus_rst_o,
  input logic       por_ready_o
);
  for (genvar i = 0; i < 5; i++) begin : g_chk
    // R1
    a_r1_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_done[i]) |-> $past(tmr_busy[i]));
    // R1
    a_r1_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_start[i] && !tmr_clr[i]) |=> (tmr_busy[i] && !tmr_done[i]));
    // R5
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr[i] |=> (!tmr_busy[i] && !tmr_done[i]));
    // R10
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(tmr_busy[i] && tmr_done[i]));
  end

  // R6
  a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_window_o) |-> (tmr_done[2] || $past(tmr_clr[2])));

  // R8
  a_r8_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(por_ready_o) |-> por_ready_o);

  // R7: reset hold length, measured from the latest request
  longint unsigned hold_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hold_len <= 0;
    else if (tmr_start[4] && !tmr_clr[4])   hold_len <= 0;
    else if (bus_rst_o)                     hold_len <= hold_len + 1;
  end

  a_r7_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rst_o) && !$past(tmr_clr[4])) |-> (hold_len == RST_CYC));
endmodule

bind bus_phase_timers bus_phase_timers_chk #(
  .RST_CYC(bus_tmr_pkg::cyc_ceil(RST_NS, CLK_KHZ))
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tmr_start    (tmr_start),
  .tmr_clr      (tmr_clr),
  .tmr_busy     (tmr_busy),
  .tmr_done     (tmr_done),
  .bsy_window_o (bsy_window_o),
  .bus_rst_o    (bus_rst_o),
  .por_ready_o  (por_ready_o)
);

// File: tb/bus_phase_timers_test.sv
`timescale 1ns/1ps
module bus_phase_timers_test;
  localparam longint unsigned KHZ = 1000;
  // expected counts worked from the rounding rules (R2, R3)
  localparam int N_ARB   = 3;    // 2400 ns, rounded up
  localparam int N_SEL   = 40;   // 40000 ns
  localparam int N_GUARD = 12;   // 12500 ns, rounded down
  localparam int N_DISC  = 30;   // 30000 ns
  localparam int N_RST   = 25;   // 25000 ns
  localparam int N_POR   = 150;  // 150700 ns, rounded down

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] tmr_start = '0;
  logic [4:0] tmr_clr = '0;
  logic [4:0] tmr_busy, tmr_done;
  logic bsy_window_o, bus_rst_o, por_ready_o;

  always #2 clk = ~clk;

  bus_phase_timers #(
    .CLK_KHZ(KHZ), .ARB_NS(2400), .SELTO_NS(40_000), .GUARD_NS(12_500),
    .DISC_NS(30_000), .RST_NS(25_000), .POR_NS(150_700)
  ) uut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int exp_q [5][$];
  int por_exp = -1;
  int nval [5] = '{N_ARB, N_SEL, N_GUARD, N_DISC, N_RST};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic pulse_start(input int i);
    @(negedge clk);
    tmr_start[i] = 1'b1;
    exp_q[i].delete();
    exp_q[i].push_back(cyc + 1 + nval[i]);
    @(negedge clk);
    tmr_start[i] = 1'b0;
  endtask

  task automatic pulse_clr(input int i);
    @(negedge clk);
    tmr_clr[i] = 1'b1;
    exp_q[i].delete();
    @(negedge clk);
    tmr_clr[i] = 1'b0;
  endtask

  // scoreboard monitor: each rising done is matched by cycle (R1, R2, R3, R4)
  logic [4:0] prev_done = '0;
  logic prev_por = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 5; i++) begin
        if (tmr_done[i] && !prev_done[i]) begin
          if (exp_q[i].size() == 0) check(1'b0, "R1/R5 unexpected done", cyc, -1);
          else begin
            int e;
            e = exp_q[i].pop_front();
            check(cyc == e, "R1/R2/R3/R4 done timing", cyc, e);
          end
        end
      end
      if (por_ready_o && !prev_por) check(cyc == por_exp, "R8 por rise", cyc, por_exp);
      prev_done = tmr_done;
      prev_por  = por_ready_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({tmr_busy, tmr_done, bsy_window_o, bus_rst_o, por_ready_o} == '0, "R9 reset state",
          int'({tmr_busy, tmr_done}), 0);
    rst_n = 1'b1;
    por_exp = cyc + N_POR;

    // R1 R2 arbitration settle, rounded up to 3
    pulse_start(0);
    check(tmr_busy[0] == 1'b1, "R1 busy after start", tmr_busy[0], 1);
    repeat (N_ARB + 2) @(negedge clk);
    check(tmr_done[0] == 1'b1, "R1 done held", tmr_done[0], 1);
    check(tmr_busy[0] == 1'b0, "R10 busy low when done", tmr_busy[0], 0);

    // R5 done cleared
    pulse_clr(0);
    check(tmr_done[0] == 1'b0, "R5 done cleared", tmr_done[0], 0);

    // R2 full selection timeout
    pulse_start(1);
    repeat (N_SEL + 2) @(negedge clk);
    check(tmr_done[1] == 1'b1, "R2 selection timeout", tmr_done[1], 1);

    // R5 cancel mid-run, no done afterwards
    pulse_start(1);
    repeat (10) @(negedge clk);
    pulse_clr(1);
    repeat (N_SEL + 5) @(negedge clk);
    check(tmr_done[1] == 1'b0 && tmr_busy[1] == 1'b0, "R5 cancelled timer silent",
          int'(tmr_done[1]), 0);

    // R4 restart of disconnect holdoff
    pulse_start(3);
    repeat (10) @(negedge clk);
    pulse_start(3);
    repeat (N_DISC - 1) @(negedge clk);
    check(tmr_done[3] == 1'b0, "R4 not done before restart count", tmr_done[3], 0);
    repeat (3) @(negedge clk);
    check(tmr_done[3] == 1'b1, "R4 done after restart count", tmr_done[3], 1);

    // R5 clear and start together: clear wins
    @(negedge clk);
    tmr_start[3] = 1'b1;
    tmr_clr[3] = 1'b1;
    exp_q[3].delete();
    @(negedge clk);
    tmr_start[3] = 1'b0;
    tmr_clr[3] = 1'b0;
    check(tmr_busy[3] == 1'b0 && tmr_done[3] == 1'b0, "R5 clear beats start",
          int'(tmr_busy[3]), 0);

    // R6 R3 response window length (rounded down to 12)
    pulse_start(2);
    n = 0;
    while (bsy_window_o) begin n++; @(negedge clk); end
    check(n == N_GUARD, "R6 window length", n, N_GUARD);
    check(tmr_done[2] == 1'b1, "R6 window end flagged", tmr_done[2], 1);

    // R7 plain reset hold
    pulse_start(4);
    n = 0;
    while (bus_rst_o) begin n++; @(negedge clk); end
    check(n == N_RST, "R7 reset hold", n, N_RST);

    // R7 retriggered reset hold: second request 10 edges after first
    pulse_start(4);
    n = 0;
    fork
      begin
        while (bus_rst_o) begin n++; @(negedge clk); end
      end
      begin
        repeat (8) @(negedge clk);
        pulse_start(4);
      end
    join
    check(n == 10 + N_RST, "R7 retrigger extends", n, 10 + N_RST);

    // R8 ready reached and held
    repeat (N_POR) @(negedge clk);
    check(por_ready_o == 1'b1, "R8 por held", por_ready_o, 1);

    repeat (5) @(negedge clk);
    for (int i = 0; i < 5; i++)
      check(exp_q[i].size() == 0, "R1 missing done", exp_q[i].size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule